// File: doc/BRIEF.md
# Compare-Match Watchdog and Interval Timer

This block is a watchdog built on a 7-bit binary counter that advances only when an upstream interval prescaler delivers an overflow strobe. The system clock alone does not advance it. Software writes a compare value. When the counter reaches that value, a match event fires and the counter restarts from zero. The time from one match to the next is the compare value multiplied by the prescaler overflow period. The same write carries a clear-request bit, which software uses to service the watchdog.

A single control enable bit picks what a match does. With the bit set, a match pulls an active-low system reset request low for a fixed window. If the system is running from its slow sub clock at that moment, the block also asks for the main oscillator to be switched back on. With the bit clear, a match only sets a sticky interrupt flag, and the block works as a plain periodic interval timer. Any system reset clears the enable bit, so software must turn watchdog operation back on after every reset. A stop-mode input freezes counting. Counting resumes by itself when stop mode ends.

Top module: `wdt_compare_watchdog`

## Requirements
- R1: The counter advances only in cycles where `tickIn` is high; idle clocks do not count. With a compare value N (1 to 127), the match occurs on the N-th accepted tick after the counter was zeroed.
- R2: A `cmpWr` pulse loads `cmpWrData[6:0]` as the compare value. If `cmpWrData[7]` is 1 in the same write, the counter is zeroed in that cycle.
- R3: When a clear request and a tick arrive in the same cycle, the clear wins. The counter ends that cycle at zero and the tick is lost.
- R4: A compare value of 0 means 128 ticks, a full wrap of the counter. The match never happens at once.
- R5: With the enable bit at 0, a match sets `irqFlag` from the next clock and `wdtResetN` stays high. The counter restarts at zero, so the next match comes after another N ticks.
- R6: `irqFlag` stays set until an `irqClr` pulse clears it. If a match coincides with `irqClr`, the flag stays set.
- R7: With the enable bit at 1, a match drives `wdtResetN` low from the next clock for exactly 16 cycles. During that window the enable bit is cleared, writes to it are ignored, and ticks are ignored with the counter held at zero. Afterwards the block behaves in interval mode.
- R8: While `rstN` is low, the enable bit, the counter and `irqFlag` are cleared, `wdtResetN` is high and `oscOnReq` is low.
- R9: While `stopIn` is high, ticks are ignored and the counter holds its value. Counting continues from that value once `stopIn` falls.
- R10: `oscOnReq` is high for exactly the reset window cycles when `subClkIn` was high in the match cycle. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| tickIn | input | 1 | One-cycle overflow strobe from the interval prescaler |
| stopIn | input | 1 | Stop mode; freezes counting while high |
| subClkIn | input | 1 | High while the system runs from the sub clock |
| cmpWr | input | 1 | Write strobe for the compare value and clear request |
| cmpWrData | input | 8 | Bit 7 is the clear request; bits 6:0 are the compare value |
| ctrlWr | input | 1 | Write strobe for the enable bit |
| ctrlEnIn | input | 1 | New enable bit value (1 selects reset mode) |
| irqClr | input | 1 | Write-one pulse that clears the interrupt flag |
| irqFlag | output | 1 | Sticky interval-timer interrupt flag |
| wdtResetN | output | 1 | Active-low watchdog reset request |
| oscOnReq | output | 1 | Request to restart the main oscillator |

## Verification
The embedded assertions check on every cycle how the counter steps. They confirm that it zeroes after a clear or a match, holds when nothing advances it, and adds exactly one on an accepted tick. They also confirm that a reset-mode match drops the reset line, that the enable bit stays clear while the reset window is active, that the interrupt flag is sticky, and that the oscillator request appears only inside the reset window. Other behaviour can only be shown by the bench's stimulus sequences, observed at the outputs. This covers the exact match period for several compare values, the 128-tick wrap for a zero compare value, and clear-versus-tick priority. It also covers the stop-mode freeze, the exact 16-cycle window, and the return to interval mode after a watchdog reset or a system reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // zero the counter this cycle
    logic advance;  // accept one tick this cycle
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_count_path.sv
module wdt_count_path
  import wdt_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic             cmpWr,
  input  logic [CNT_W-1:0] cmpData,
  output logic             matchHit
);
  localparam logic [CNT_W:0] FULL_WRAP = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE_EXT   = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W:0]   nextCnt;
  logic [CNT_W:0]   terminal;

  always_comb begin
    nextCnt  = {1'b0, cnt} + ONE_EXT;
    terminal = (cmpReg == '0) ? FULL_WRAP : {1'b0, cmpReg};
    matchHit = strobe.advance && (nextCnt == terminal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      cmpReg <= '1;
    end else begin
      if (cmpWr) cmpReg <= cmpData;
      if (strobe.clrCnt)       cnt <= '0;
      else if (matchHit)       cnt <= '0;
      else if (strobe.advance) cnt <= nextCnt[CNT_W-1:0];
    end
  end

  // R2, R3: a clear leaves the counter at zero
  assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> cnt == '0);
  // R5: counter restarts after a match
  assert_match_restarts_R5: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> cnt == '0);
  // R9: nothing moves the counter without a strobe
  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrCnt && !strobe.advance) |=> $stable(cnt));
  // R1: an accepted tick adds exactly one
  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clrCnt && !matchHit) |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       stopIn,
  input  logic       subClkIn,
  input  logic       clrReq,
  input  logic       ctrlWr,
  input  logic       ctrlEnIn,
  input  logic       irqClr,
  input  logic       matchHit,
  output wdtStrobe_t strobe,
  output logic       irqFlag,
  output logic       wdtResetN,
  output logic       oscOnReq
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_LEN);
  localparam logic [PW-1:0] PULSE_ONE  = PW'(1);

  logic          enReg;
  logic [PW-1:0] pulseCnt;
  logic          pulseActive;
  logic          startPulse;

  always_comb begin
    pulseActive    = (pulseCnt != '0);
    strobe.clrCnt  = clrReq || pulseActive;
    strobe.advance = tickIn && !stopIn && !clrReq && !pulseActive;
    startPulse     = matchHit && enReg;
    wdtResetN      = !pulseActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      pulseCnt <= '0;
      irqFlag  <= 1'b0;
      oscOnReq <= 1'b0;
    end else begin
      if (startPulse || pulseActive) enReg <= 1'b0;
      else if (ctrlWr)               enReg <= ctrlEnIn;

      if (startPulse)       pulseCnt <= PULSE_INIT;
      else if (pulseActive) pulseCnt <= pulseCnt - PULSE_ONE;

      if (startPulse)                oscOnReq <= subClkIn;
      else if (pulseCnt == PULSE_ONE) oscOnReq <= 1'b0;

      if (matchHit && !enReg) irqFlag <= 1'b1;
      else if (irqClr)        irqFlag <= 1'b0;
    end
  end

  // R7: a reset-mode match opens the reset window
  assert_match_resets_R7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !wdtResetN);
  // R7: enable stays clear while the window is open
  assert_enable_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wdtResetN |-> !enReg);
  // R5: an interval-mode match raises the flag
  assert_irq_on_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && !enReg) |=> irqFlag);
  // R6: the flag is sticky until cleared
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);
  // R10: oscillator request only inside the reset window
  assert_osc_in_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    oscOnReq |-> !wdtResetN);
endmodule

// File: rtl/wdt_compare_watchdog.sv
module wdt_compare_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int PULSE_LEN = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tickIn,
  input  logic           stopIn,
  input  logic           subClkIn,
  input  logic           cmpWr,
  input  logic [CNT_W:0] cmpWrData,
  input  logic           ctrlWr,
  input  logic           ctrlEnIn,
  input  logic           irqClr,
  output logic           irqFlag,
  output logic           wdtResetN,
  output logic           oscOnReq
);
  wdtStrobe_t strobe;
  logic       matchHit;
  logic       clrReq;

  assign clrReq = cmpWr && cmpWrData[CNT_W];

  wdt_count_path #(.CNT_W(CNT_W)) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmpWr   (cmpWr),
    .cmpData (cmpWrData[CNT_W-1:0]),
    .matchHit(matchHit)
  );

  wdt_ctrl #(.PULSE_LEN(PULSE_LEN)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .stopIn   (stopIn),
    .subClkIn (subClkIn),
    .clrReq   (clrReq),
    .ctrlWr   (ctrlWr),
    .ctrlEnIn (ctrlEnIn),
    .irqClr   (irqClr),
    .matchHit (matchHit),
    .strobe   (strobe),
    .irqFlag  (irqFlag),
    .wdtResetN(wdtResetN),
    .oscOnReq (oscOnReq)
  );
endmodule

// File: tb/test_wdt_compare_watchdog.sv
`timescale 1ns/1ps
module test_wdt_compare_watchdog;
  logic clk = 1'b0;
  logic rstN, tickIn, stopIn, subClkIn, cmpWr, ctrlWr, ctrlEnIn, irqClr;
  logic [7:0] cmpWrData;
  logic irqFlag, wdtResetN, oscOnReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    int    sel;   // 0 irqFlag, 1 wdtResetN, 2 oscOnReq
    logic  exp;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  wdt_compare_watchdog i_wdt_compare_watchdog (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .stopIn(stopIn), .subClkIn(subClkIn),
    .cmpWr(cmpWr), .cmpWrData(cmpWrData), .ctrlWr(ctrlWr), .ctrlEnIn(ctrlEnIn),
    .irqClr(irqClr), .irqFlag(irqFlag), .wdtResetN(wdtResetN), .oscOnReq(oscOnReq)
  );

  // Monitor: compares queued expectations half a cycle after each edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      logic act;
      it  = expQ.pop_front();
      act = (it.sel == 0) ? irqFlag : (it.sel == 1) ? wdtResetN : oscOnReq;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sig%0d: actual=%0b expected=%0b", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_sig(string tag, int sel, logic val);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.exp = val;
    expQ.push_back(it);
  endtask

  task automatic writeCmp(logic [7:0] d, logic withTick);
    cmpWr = 1'b1; cmpWrData = d; tickIn = withTick;
    cyc();
    cmpWr = 1'b0; tickIn = 1'b0;
  endtask

  task automatic clearIrq(string tag);
    irqClr = 1'b1;
    cyc();
    irqClr = 1'b0;
    expect_sig(tag, 0, 1'b0);
  endtask

  // n ticks separated by idle clocks; irq expected baseIrq, last one lastIrq
  task automatic ticks(int n, logic baseIrq, logic lastIrq, string tag);
    for (int i = 0; i < n; i++) begin
      tickIn = 1'b1;
      cyc();
      tickIn = 1'b0;
      expect_sig(tag, 0, (i == n - 1) ? lastIrq : baseIrq);
      expect_sig(tag, 1, 1'b1);
      cyc();
    end
  endtask

  task automatic resetWindow(logic oscExp, string tag);
    tickIn = 1'b1;
    cyc();
    expect_sig(tag, 1, 1'b0);
    expect_sig({tag, " R10"}, 2, oscExp);
    for (int k = 2; k <= 16; k++) begin
      ctrlWr = 1'b1; ctrlEnIn = 1'b1;   // ignored inside the window
      cyc();
      expect_sig(tag, 1, 1'b0);
      expect_sig({tag, " R10"}, 2, oscExp);
    end
    tickIn = 1'b0; ctrlWr = 1'b0; ctrlEnIn = 1'b0;
    cyc();
    expect_sig({tag, " end"}, 1, 1'b1);
    expect_sig({tag, " R10 end"}, 2, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; tickIn = 0; stopIn = 0; subClkIn = 0; cmpWr = 0; cmpWrData = '0;
    ctrlWr = 0; ctrlEnIn = 0; irqClr = 0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    expect_sig("R8 reset irq", 0, 1'b0);
    expect_sig("R8 reset rst", 1, 1'b1);
    expect_sig("R8 reset osc", 2, 1'b0);

    // R1 / R5: compare 5, interval mode
    writeCmp(8'h85, 1'b0);
    ticks(5, 1'b0, 1'b1, "R1 period 5");
    repeat (3) begin cyc(); expect_sig("R6 sticky", 0, 1'b1); end
    clearIrq("R6 clear");
    ticks(5, 1'b0, 1'b1, "R5 restart");
    // R6: match coinciding with clear keeps the flag
    ticks(4, 1'b1, 1'b1, "R6 held");
    tickIn = 1'b1; irqClr = 1'b1;
    cyc();
    tickIn = 1'b0; irqClr = 1'b0;
    expect_sig("R6 set wins", 0, 1'b1);
    clearIrq("R6 clear2");

    // R3: clear with simultaneous tick
    ticks(4, 1'b0, 1'b0, "R3 pre");
    writeCmp(8'h85, 1'b1);
    expect_sig("R3 no match", 0, 1'b0);
    ticks(5, 1'b0, 1'b1, "R3 after clear");
    clearIrq("R3 clr");

    // R2: clear bit plus new compare value
    ticks(3, 1'b0, 1'b0, "R2 pre");
    writeCmp(8'h83, 1'b0);
    ticks(3, 1'b0, 1'b1, "R2 compare 3");
    clearIrq("R2 clr");

    // R9: stop freezes
    writeCmp(8'h84, 1'b0);
    ticks(2, 1'b0, 1'b0, "R9 pre");
    stopIn = 1'b1;
    ticks(5, 1'b0, 1'b0, "R9 stopped");
    stopIn = 1'b0;
    ticks(2, 1'b0, 1'b1, "R9 resume");
    clearIrq("R9 clr");

    // R4: compare 0 is 128 ticks
    writeCmp(8'h80, 1'b0);
    ticks(128, 1'b0, 1'b1, "R4 wrap");
    clearIrq("R4 clr");

    // R7: reset mode, main clock
    writeCmp(8'h82, 1'b0);
    ctrlWr = 1'b1; ctrlEnIn = 1'b1;
    cyc();
    ctrlWr = 1'b0; ctrlEnIn = 1'b0;
    ticks(1, 1'b0, 1'b0, "R7 pre");
    resetWindow(1'b0, "R7 window");
    expect_sig("R7 no irq", 0, 1'b0);
    ticks(2, 1'b0, 1'b1, "R7 interval after");
    clearIrq("R7 clr");

    // R10: reset mode from the sub clock
    subClkIn = 1'b1;
    ctrlWr = 1'b1; ctrlEnIn = 1'b1;
    cyc();
    ctrlWr = 1'b0; ctrlEnIn = 1'b0;
    ticks(1, 1'b0, 1'b0, "R10 pre");
    resetWindow(1'b1, "R10 window");
    subClkIn = 1'b0;

    // R8: system reset clears the enable bit and the flag
    ctrlWr = 1'b1; ctrlEnIn = 1'b1;
    cyc();
    ctrlWr = 1'b0; ctrlEnIn = 1'b0;
    ticks(1, 1'b0, 1'b0, "R8 pre");
    rstN = 1'b0;
    cyc();
    rstN = 1'b1;
    cyc();
    expect_sig("R8 after reset", 1, 1'b1);
    writeCmp(8'h82, 1'b0);
    ticks(2, 1'b0, 1'b1, "R8 enable cleared");
    expect_sig("R8 osc low", 2, 1'b0);

    repeat (3) cyc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule